// File: doc/BRIEF.md
# Command ring read pointer engine

This block owns the consumer side of a command ring that lives in host memory. The ring has 256 slots of one 32-bit command each. While software lets the engine run, it fetches commands one at a time through a simple memory read port, puts them in a four-entry local queue, and hands them to a downstream link over a ready/valid stream. An 8-bit index tells software the last slot that has been fetched; that slot, and every slot before it back to the previous write position, may be reused by software.

Software sees one 16-bit register. The low byte holds the fetch index and is read-only. The top bit controls a two-phase pointer reset. Software writes 1 and the engine waits until it is stopped. It then zeroes the index and drops every queued command, and sets the top bit to 1 as an acknowledge. Software ends the exchange by writing 0. A read that is in flight when the reset happens is discarded when its data returns.

Top module: `cmd_ring_rdptr`

## Requirements
- R1: After reset the register reads 16'h0000, `cmd_valid_o` is 0 and `mem_req_o` is 0.
- R2: `mem_req_o` is high only while `run_i` is 1, the index differs from `wr_ptr_i`, bit 15 reads 0 with no reset pending, no read is outstanding and the queue is not full. The requested slot is index+1 modulo 256. The request is held until `mem_gnt_i` accepts it.
- R3: Each accepted response advances the index in bits 7:0 by one, wrapping from 255 to 0, one edge after the response is sampled.
- R4: Commands leave on `cmd_data_o` in ring order, equal to the fetched memory words, with a handshake on `cmd_valid_o`/`cmd_ready_i`.
- R5: The local queue holds 4 commands. With `cmd_ready_i` low the engine fetches exactly 4 entries and then stops requesting.
- R6: Writes to bits 14:0 have no effect. Bits 14:8 always read 0, and bits 7:0 change only by fetching or by a pointer reset.
- R7: Writing 1 to bit 15 while `run_i` is high leaves bit 15 reading 0 and the index unchanged until the engine is stopped. No new fetch starts while bit 15 is set or a reset is pending.
- R8: When a reset is pending and `run_i` is low, one edge later the index is 0, the queue is empty (`cmd_valid_o` 0) and bit 15 reads 1.
- R9: Writing 0 to bit 15 makes it read 0 after the write edge, and fetching resumes from index 0.
- R10: The response to a read that is outstanding when the reset happens is discarded. It neither moves the index nor reaches `cmd_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Engine run enable |
| wr_ptr_i | input | 8 | Software write index of the ring |
| reg_wr_i | input | 1 | Write strobe for the pointer register |
| reg_wdata_i | input | 16 | Write data; only bit 15 is writable |
| reg_rdata_o | output | 16 | Register read value: bit 15 reset/ack, bits 7:0 index |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 8 | Slot index being read |
| mem_gnt_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| cmd_valid_o | output | 1 | Command available downstream |
| cmd_data_o | output | 32 | Command word |
| cmd_ready_i | input | 1 | Downstream accepts the command |

## Verification
A request appears on `mem_req_o` in the same cycle as the inputs that allow it, because it is combinational from state. A sampled response moves the index and makes the command visible after one edge. A register write captured at edge N moves a stopped engine into reset at edge N+1, so the acknowledge reads 1 after that edge. All inputs change on the falling edge, and each check samples on a falling edge at the point its latency says the result is due. The memory model answers after a latency the bench can set. This lets a reset land while a read is still in flight, and the bench then checks that the late word is never delivered. A sweep takes the index through the full ring and across its wrap, and compares every delivered word with a value computed from its slot number.

// File: rtl/cring_pkg.sv
package cring_pkg;
    localparam int unsigned REG_W   = 16;
    localparam int unsigned ACK_BIT = 15;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_PEND = 2'd1,
        HS_DONE = 2'd2
    } hs_e;
endpackage

// File: rtl/cring_fifo.sv
module cring_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          push_i,
    input  logic [W-1:0]  push_data_i,
    input  logic          pop_ready_i,
    output logic          pop_valid_o,
    output logic [W-1:0]  pop_data_o,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_s;

    fifo_s q, d;
    logic [W-1:0] store_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push_i && (q.cnt != CW'(DEPTH));
        do_pop  = (q.cnt != '0) && pop_ready_i;
        if (flush_i) begin
            d = '0;
        end else begin
            if (do_push) d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + AW'(1);
            if (do_pop)  d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + AW'(1);
            if (do_push && !do_pop) d.cnt = q.cnt + CW'(1);
            if (do_pop && !do_push) d.cnt = q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush_i) store_q[q.wp] <= push_data_i;
    end

    assign pop_valid_o = (q.cnt != '0);
    assign pop_data_o  = store_q[q.rp];
    assign count_o     = q.cnt;
endmodule

// File: rtl/cring_ctrl.sv
module cring_ctrl
    import cring_pkg::*;
#(
    parameter int unsigned PTR_W      = 8,
    parameter int unsigned FIFO_DEPTH = 4,
    localparam int unsigned FCW       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PTR_W-1:0] wr_ptr_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    input  logic             mem_gnt_i,
    input  logic             mem_rvalid_i,
    input  logic [FCW-1:0]   fifo_count_i,
    output logic             mem_req_o,
    output logic [PTR_W-1:0] mem_addr_o,
    output logic             push_o,
    output logic             flush_o,
    output logic             ack_o,
    output logic [PTR_W-1:0] rd_ptr_o
);
    localparam logic [REG_W-1:0] WR_MASK = REG_W'(1) << ACK_BIT;

    typedef struct packed {
        logic [PTR_W-1:0] rp;
        hs_e              hs;
        logic             busy;
        logic             drop;
    } ctrl_s;

    ctrl_s q, d;
    logic resp, room, do_reset, wr_one;

    always_comb begin
        d         = q;
        resp      = q.busy && mem_rvalid_i;
        room      = fifo_count_i < FCW'(FIFO_DEPTH);
        do_reset  = (q.hs == HS_PEND) && !run_i;
        wr_one    = (reg_wdata_i & WR_MASK) != '0;
        mem_req_o = run_i && (q.hs == HS_IDLE) && !q.busy
                    && (q.rp != wr_ptr_i) && room;
        push_o    = resp && !q.drop && !do_reset;
        flush_o   = do_reset;

        if (resp) begin
            d.busy = 1'b0;
            d.drop = 1'b0;
            if (push_o) d.rp = q.rp + PTR_W'(1);
        end
        if (mem_req_o && mem_gnt_i) d.busy = 1'b1;

        if (do_reset) begin
            d.rp = '0;
            d.hs = HS_DONE;
            if (q.busy && !resp) d.drop = 1'b1;
        end

        if (reg_wr_i) begin
            if (!wr_one)                d.hs = HS_IDLE;
            else if (q.hs == HS_IDLE)   d.hs = HS_PEND;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{rp: '0, hs: HS_IDLE, busy: 1'b0, drop: 1'b0};
        else        q <= d;
    end

    assign mem_addr_o = q.rp + PTR_W'(1);
    assign ack_o      = (q.hs == HS_DONE);
    assign rd_ptr_o   = q.rp;
endmodule

// File: rtl/cmd_ring_rdptr.sv
module cmd_ring_rdptr
    import cring_pkg::*;
#(
    parameter int unsigned PTR_W      = 8,
    parameter int unsigned CMD_W      = 32,
    parameter int unsigned FIFO_DEPTH = 4,
    localparam int unsigned RSV_W     = REG_W - 1 - PTR_W,
    localparam int unsigned FCW       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PTR_W-1:0] wr_ptr_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             mem_req_o,
    output logic [PTR_W-1:0] mem_addr_o,
    input  logic             mem_gnt_i,
    input  logic             mem_rvalid_i,
    input  logic [CMD_W-1:0] mem_rdata_i,
    output logic             cmd_valid_o,
    output logic [CMD_W-1:0] cmd_data_o,
    input  logic             cmd_ready_i
);
    logic             push, flush, ack;
    logic [PTR_W-1:0] rd_ptr;
    logic [FCW-1:0]   fill;

    cring_ctrl #(.PTR_W(PTR_W), .FIFO_DEPTH(FIFO_DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_i),
        .wr_ptr_i     (wr_ptr_i),
        .reg_wr_i     (reg_wr_i),
        .reg_wdata_i  (reg_wdata_i),
        .mem_gnt_i    (mem_gnt_i),
        .mem_rvalid_i (mem_rvalid_i),
        .fifo_count_i (fill),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .push_o       (push),
        .flush_o      (flush),
        .ack_o        (ack),
        .rd_ptr_o     (rd_ptr)
    );

    cring_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush),
        .push_i      (push),
        .push_data_i (mem_rdata_i),
        .pop_ready_i (cmd_ready_i),
        .pop_valid_o (cmd_valid_o),
        .pop_data_o  (cmd_data_o),
        .count_o     (fill)
    );

    assign reg_rdata_o = {ack, {RSV_W{1'b0}}, rd_ptr};
endmodule

// File: rtl/cmd_ring_rdptr_chk.sv
module cmd_ring_rdptr_chk #(
    parameter int unsigned PTR_W = 8,
    parameter int unsigned CMD_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_i,
    input logic [PTR_W-1:0] wr_ptr_i,
    input logic [15:0]      reg_rdata_o,
    input logic             mem_req_o,
    input logic             mem_gnt_i,
    input logic             mem_rvalid_i,
    input logic             cmd_valid_o,
    input logic [CMD_W-1:0] cmd_data_o,
    input logic             cmd_ready_i
);
    logic out_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      out_q <= 1'b0;
        else if (mem_req_o && mem_gnt_i) out_q <= 1'b1;
        else if (mem_rvalid_i)           out_q <= 1'b0;
    end

    p_req_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (run_i && reg_rdata_o[PTR_W-1:0] != wr_ptr_i));

    p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !out_q);

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o[PTR_W-1:0] != $past(reg_rdata_o[PTR_W-1:0]))
        |-> ((reg_rdata_o[PTR_W-1:0] == $past(reg_rdata_o[PTR_W-1:0]) + PTR_W'(1))
             || (reg_rdata_o[PTR_W-1:0] == '0)));

    p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i)
        |=> ((cmd_valid_o && $stable(cmd_data_o)) || $rose(reg_rdata_o[15])));

    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[14:PTR_W] == '0);

    p_no_fetch_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[15] |-> !mem_req_o);

    p_ack_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata_o[15]) |-> (!$past(run_i) && !cmd_valid_o
                                    && reg_rdata_o[PTR_W-1:0] == '0));
endmodule

bind cmd_ring_rdptr cmd_ring_rdptr_chk #(.PTR_W(PTR_W), .CMD_W(CMD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run_i),
    .wr_ptr_i     (wr_ptr_i),
    .reg_rdata_o  (reg_rdata_o),
    .mem_req_o    (mem_req_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_data_o   (cmd_data_o),
    .cmd_ready_i  (cmd_ready_i)
);

// File: tb/tb_cmd_ring_rdptr.sv
`timescale 1ns/1ps
module tb_cmd_ring_rdptr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [7:0]  wp = 8'd0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        mem_req;
    logic [7:0]  mem_addr;
    logic        mem_gnt = 1'b1;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic        cmd_valid;
    logic [31:0] cmd_data;
    logic        cmd_ready = 1'b1;

    int n_chk = 0;
    int n_err = 0;
    int gi = 0;
    int lat_cfg = 2;
    logic [31:0] got [$];

    always #2.5 clk = ~clk;

    cmd_ring_rdptr dut (
        .clk(clk), .rst_n(rst_n), .run_i(run), .wr_ptr_i(wp),
        .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .cmd_valid_o(cmd_valid), .cmd_data_o(cmd_data), .cmd_ready_i(cmd_ready)
    );

    function automatic logic [31:0] word_of(input logic [7:0] a);
        return {16'hC0DE, a, ~a};
    endfunction

    // memory model and downstream sink, both acting as registers on the rising edge
    logic       pend = 1'b0;
    logic [7:0] pend_a = 8'd0;
    int         pend_cnt = 0;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= word_of(pend_a);
                pend = 1'b0;
            end else begin
                pend_cnt = pend_cnt - 1;
            end
        end
        if (mem_req && mem_gnt) begin
            pend = 1'b1;
            pend_a = mem_addr;
            pend_cnt = lat_cfg - 1;
        end
        if (cmd_valid && cmd_ready) got.push_back(cmd_data);
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [15:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = 16'h0;
    endtask

    task automatic wait_ptr(input logic [7:0] t, input string req);
        int k = 0;
        while (reg_rdata[7:0] != t && k < 2000) begin
            @(negedge clk);
            k++;
        end
        repeat (6) @(negedge clk);
        check(reg_rdata[7:0] == t, req, {24'h0, reg_rdata[7:0]}, {24'h0, t});
    endtask

    task automatic check_run(input logic [7:0] first, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            logic [7:0] a;
            a = first + 8'(k);
            if (gi < got.size()) check(got[gi] == word_of(a), req, got[gi], word_of(a));
            else                 check(1'b0, req, 32'hDEAD_DEAD, word_of(a));
            gi++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(reg_rdata == 16'h0000, "R1 reg", {16'h0, reg_rdata}, 32'h0);
        check(!cmd_valid && !mem_req, "R1 outputs", {30'h0, cmd_valid, mem_req}, 32'h0);

        // R2 no fetch when write index equals read index
        run = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(!mem_req, "R2 idle no request", {31'h0, mem_req}, 32'h0);
        end

        // R3/R4 fetch a first batch
        wp = 8'd10;
        wait_ptr(8'd10, "R3 index after batch");
        check_run(8'd1, 10, "R4 batch order");

        // R5 queue depth with downstream stalled
        cmd_ready = 1'b0;
        wp = 8'd30;
        repeat (40) @(negedge clk);
        check(reg_rdata[7:0] == 8'd14, "R5 fetch stops at depth", {24'h0, reg_rdata[7:0]}, 32'd14);
        check(!mem_req && cmd_valid, "R5 full queue", {30'h0, mem_req, cmd_valid}, 32'h1);
        cmd_ready = 1'b1;
        wait_ptr(8'd30, "R5 drain");
        check_run(8'd11, 20, "R4 stalled order");

        // R2 request held until granted
        mem_gnt = 1'b0;
        wp = 8'd31;
        repeat (5) @(negedge clk);
        check(mem_req && mem_addr == 8'd31, "R2 held request", {23'h0, mem_req, mem_addr}, {23'h0, 1'b1, 8'd31});
        check(reg_rdata[7:0] == 8'd30, "R2 no grant no advance", {24'h0, reg_rdata[7:0]}, 32'd30);
        mem_gnt = 1'b1;
        wait_ptr(8'd31, "R2 grant");
        check_run(8'd31, 1, "R4 after grant");

        // R3 sweep across the wrap, longer memory latency
        lat_cfg = 3;
        wp = 8'd0;
        wait_ptr(8'd0, "R3 wrap to zero");
        check_run(8'd32, 225, "R3 wrap sweep data");

        // R6 writes to low bits ignored
        lat_cfg = 2;
        wp = 8'd5;
        wait_ptr(8'd5, "R3 post wrap");
        check_run(8'd1, 5, "R4 post wrap");
        reg_write(16'h7FAA);
        @(negedge clk);
        check(reg_rdata == 16'h0005, "R6 ignored bits", {16'h0, reg_rdata}, 32'h5);

        // R7 request held off while running
        reg_write(16'h8000);
        wp = 8'd9;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(!mem_req, "R7 no fetch while pending", {31'h0, mem_req}, 32'h0);
        end
        check(reg_rdata == 16'h0005, "R7 held while running", {16'h0, reg_rdata}, 32'h5);

        // R9 cancel, then fill the queue with downstream stalled
        cmd_ready = 1'b0;
        reg_write(16'h0000);
        check(reg_rdata[15] == 1'b0, "R9 bit clear", {31'h0, reg_rdata[15]}, 32'h0);
        wait_ptr(8'd9, "R9 fetch resumes");

        // R8 reset when stopped flushes queue
        run = 1'b0;
        reg_write(16'h8000);
        check(reg_rdata[15] == 1'b0, "R8 not yet acknowledged", {31'h0, reg_rdata[15]}, 32'h0);
        @(negedge clk);
        check(reg_rdata == 16'h8000, "R8 ack and zero index", {16'h0, reg_rdata}, 32'h8000);
        check(!cmd_valid, "R8 queue flushed", {31'h0, cmd_valid}, 32'h0);
        cmd_ready = 1'b1;
        repeat (5) @(negedge clk);
        check(got.size() == gi, "R8 flushed words not delivered", got.size(), gi);

        // R7 no fetch while bit 15 reads 1
        run = 1'b1;
        wp = 8'd3;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(!mem_req, "R7 no fetch while acknowledged", {31'h0, mem_req}, 32'h0);
        end
        reg_write(16'h0000);
        check(reg_rdata == 16'h0000, "R9 handshake closed", {16'h0, reg_rdata}, 32'h0);
        wait_ptr(8'd3, "R9 restart from zero");
        check_run(8'd1, 3, "R9 restart data");

        // R10 reset while a read is in flight
        lat_cfg = 6;
        wp = 8'd5;
        @(negedge clk);
        run = 1'b0;
        reg_write(16'h8000);
        repeat (12) @(negedge clk);
        check(reg_rdata == 16'h8000, "R10 index stays zero", {16'h0, reg_rdata}, 32'h8000);
        check(!cmd_valid && got.size() == gi, "R10 late word dropped", {31'h0, cmd_valid}, 32'h0);
        lat_cfg = 2;
        reg_write(16'h0000);
        wp = 8'd2;
        run = 1'b1;
        wait_ptr(8'd2, "R10 refetch");
        check_run(8'd1, 2, "R10 fresh data");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog R4 actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
        $finish;
    end
endmodule